// File: doc/BRIEF.md
# Chainable 24-Bit Serial Command Receiver

This block is the serial front end of a high-resolution converter. A host selects it with an active-low select line, clocks 24-bit frames on a serial clock that idles low, and the block decodes each frame into a 4-bit command and an 18-bit data word. A complete frame can load the 18-bit input register, load a two-bit configuration register, or request that a register be returned on the echo output. The block samples the select, serial clock and data pins with a fast system clock, so every pin level must last a few system clocks.

The echo output repeats the received frame one bit late, or returns a register in place of the data field during a readback. It has a separate drive enable. After a frame it can release the line or keep driving its last bit. A ready output goes low once the frame is complete and stays low until select is released. It can drive the select input of the next device, so several devices can share one data line and one clock in a chain.

Top module: `spi_cmd_slave`

## Requirements
- R1: Bits arrive MSB first and are captured on falling serial-clock edges: 4 command bits, then data D17..D0, then 2 ignored bits. On the 24th falling edge after select falls, command 0x1 loads D17..D0 into `input_reg`. In every complete frame, `exec_stb` is high for exactly one system clock and `exec_cmd` holds the command.
- R2: Command 0x4 loads data bits D1..D0 into the configuration: D0 drives `echo_en` and D1 drives `hiz_after`. Command 0x0 changes no register, but it still raises the strobe.
- R3: If select rises before the 24th falling edge, no register changes and no strobe occurs.
- R4: Falling edges after the 24th in the same select-low period are ignored. The command executes as if the frame had ended at bit 24.
- R5: While select is high, serial clock and data activity is ignored. The next frame is then decoded from its own first bit.
- R6: While `echo_en` is 1, the echo output is updated after each rising edge of a frame. It shows 0 in bit slot 1, and in slot k (2..24) it shows received bit k-1.
- R7: After reset, `dout_oe` is 0, and it stays 0 during every frame while `echo_en` is 0.
- R8: With `hiz_after` = 1, `dout_oe` drops after the 24th falling edge and whenever select is high. With `hiz_after` = 0, a driven echo stays enabled after the frame and holds its last bit.
- R9: `ready_n` goes low after the 24th falling edge of a frame. It is high before that edge and returns high once select is high.
- R10: A command with bit 3 set is a readback, and its low three bits select the register: 1 returns `input_reg`, 4 returns the configuration zero-extended to 18 bits, and any other value returns zeros. Echo slots 6..23 carry that register MSB first, while slots 1..5 and 24 follow R6.
- R11: When the `ready_n` of one device drives the select of a second device, and both share the clock and data lines, a 48-bit transfer delivers bits 1..24 to the first device and bits 25..48 to the second.
- R12: Reset clears `input_reg`, the configuration, `exec_stb` and `exec_cmd`, and sets `ready_n` to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low frame select |
| sclk | input | 1 | Serial clock, idles low |
| din | input | 1 | Serial data in, MSB first |
| dout | output | 1 | Echo / readback serial data |
| dout_oe | output | 1 | Drive enable for `dout` |
| ready_n | output | 1 | Low once a frame is complete; select for the next device |
| input_reg | output | 18 | 18-bit input register |
| echo_en | output | 1 | Configuration: echo output enabled |
| hiz_after | output | 1 | Configuration: release echo line after frame |
| exec_stb | output | 1 | One-clock pulse when a frame executes |
| exec_cmd | output | 4 | Command of the last executed frame |

## Verification
The bench sends a 20-bit frame and a 12-bit frame that are cut short. A receiver that commits on select rise instead of on bit 24 would corrupt `input_reg` or the configuration there. It also sends a 30-bit frame with ones in the surplus bits: a counter that does not stop at 24 would shift those ones into the data, or the frame would never execute. Every echo slot is compared, so an echo that is off by one slot, or that runs ahead of din, shows up at once. Readback frames catch a register that is picked from the wrong field. Clocks toggled while select is high catch a bit counter that is not held during that time. In the two-device chain, the second device only gets the right word if `ready_n` falls exactly after bit 24.

// File: rtl/spi_cmd_slave.sv
module spi_cmd_slave #(
  parameter int CMD_W       = 4,
  parameter int DATA_W      = 18,
  parameter int PAD_W       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              din,
  output logic              dout,
  output logic              dout_oe,
  output logic              ready_n,
  output logic [DATA_W-1:0] input_reg,
  output logic              echo_en,
  output logic              hiz_after,
  output logic              exec_stb,
  output logic [CMD_W-1:0]  exec_cmd
);
  localparam int FRAME_W = CMD_W + DATA_W + PAD_W;
  localparam int CNT_W   = $clog2(FRAME_W + 1);
  localparam logic [CMD_W-1:0] OP_NOP    = CMD_W'(0);
  localparam logic [CMD_W-1:0] OP_WR_IN  = CMD_W'(1);
  localparam logic [CMD_W-1:0] OP_WR_CFG = CMD_W'(4);
  localparam logic [CMD_W-2:0] RB_IN     = OP_WR_IN[CMD_W-2:0];
  localparam logic [CMD_W-2:0] RB_CFG    = OP_WR_CFG[CMD_W-2:0];

  logic [SYNC_STAGES-1:0] cs_sync, sclk_sync, din_sync;
  logic                   sclk_prev;
  logic                   cs_s, sclk_s, din_s;
  logic                   sclk_rise, sclk_fall, last_bit;
  logic [CNT_W-1:0]       cnt, rb_idx;
  logic [FRAME_W-1:0]     shift_q, frame_nxt;
  logic [CMD_W-1:0]       cmd_q, cmd_nxt;
  logic [DATA_W-1:0]      data_nxt, rb_word;
  logic [1:0]             cfg_q, cfg_nxt;
  logic                   dout_q, drive_q, echo_bit;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cs_sync   <= '1;
      sclk_sync <= '0;
      din_sync  <= '0;
      sclk_prev <= 1'b0;
    end else begin
      cs_sync   <= {cs_sync[SYNC_STAGES-2:0], cs_n};
      sclk_sync <= {sclk_sync[SYNC_STAGES-2:0], sclk};
      din_sync  <= {din_sync[SYNC_STAGES-2:0], din};
      sclk_prev <= sclk_s;
    end

  assign cs_s      = cs_sync[SYNC_STAGES-1];
  assign sclk_s    = sclk_sync[SYNC_STAGES-1];
  assign din_s     = din_sync[SYNC_STAGES-1];
  assign sclk_rise = !cs_s && sclk_s && !sclk_prev;
  assign sclk_fall = !cs_s && !sclk_s && sclk_prev;
  assign last_bit  = sclk_fall && (cnt == CNT_W'(FRAME_W - 1));

  assign frame_nxt = {shift_q[FRAME_W-2:0], din_s};
  assign cmd_nxt   = frame_nxt[FRAME_W-1 -: CMD_W];
  assign data_nxt  = frame_nxt[FRAME_W-1-CMD_W -: DATA_W];
  assign cfg_nxt   = (last_bit && cmd_nxt == OP_WR_CFG) ? data_nxt[1:0] : cfg_q;

  always_comb begin
    case (cmd_q[CMD_W-2:0])
      RB_IN:   rb_word = input_reg;
      RB_CFG:  rb_word = DATA_W'(cfg_q);
      default: rb_word = '0;
    endcase
  end

  always_comb begin
    rb_idx = CNT_W'(CMD_W + DATA_W) - cnt;
    if (cnt == '0)
      echo_bit = 1'b0;
    else if (cmd_q[CMD_W-1] && cnt > CNT_W'(CMD_W) && cnt <= CNT_W'(CMD_W + DATA_W))
      echo_bit = rb_word[rb_idx];
    else
      echo_bit = shift_q[0];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt       <= '0;
      shift_q   <= '0;
      cmd_q     <= OP_NOP;
      input_reg <= '0;
      cfg_q     <= '0;
      dout_q    <= 1'b0;
      drive_q   <= 1'b0;
      exec_stb  <= 1'b0;
      exec_cmd  <= OP_NOP;
    end else begin
      exec_stb <= last_bit;
      cfg_q    <= cfg_nxt;
      if (cs_s) begin
        cnt <= '0;
        if (cfg_q[1]) drive_q <= 1'b0;
      end else begin
        if (sclk_rise && cnt < CNT_W'(FRAME_W) && cfg_q[0]) begin
          dout_q  <= echo_bit;
          drive_q <= 1'b1;
        end
        if (sclk_fall && cnt < CNT_W'(FRAME_W)) begin
          shift_q <= frame_nxt;
          cnt     <= cnt + 1'b1;
          if (cnt == CNT_W'(CMD_W - 1)) cmd_q <= frame_nxt[CMD_W-1:0];
        end
        if (last_bit) begin
          exec_cmd <= cmd_nxt;
          if (cmd_nxt == OP_WR_IN) input_reg <= data_nxt;
          if (!cfg_nxt[0] || cfg_nxt[1]) drive_q <= 1'b0;
        end
      end
    end

  assign echo_en   = cfg_q[0];
  assign hiz_after = cfg_q[1];
  assign dout      = dout_q;
  assign dout_oe   = drive_q;
  assign ready_n   = (cnt != CNT_W'(FRAME_W));

  // R4
  cnt_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(FRAME_W));

  // R1
  input_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(input_reg) |-> (exec_stb && exec_cmd == OP_WR_IN));

  // R1
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exec_stb |=> !exec_stb);

  // R9
  ready_on_exec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ready_n) |-> exec_stb);

  // R9
  ready_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |=> ready_n);

  // R7
  echo_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !echo_en |-> !dout_oe);

  // R8
  hiz_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hiz_after && !ready_n) |-> !dout_oe);
endmodule

// File: tb/sim_spi_cmd_slave.sv
`timescale 1ns/1ps
module sim_spi_cmd_slave;
  localparam int H = 8;

  logic clk = 0, rst_n = 0, cs_n = 1, sclk = 0, din = 0;
  logic dout0, oe0, rdy0, en0, hz0, stb0;
  logic [17:0] in0;
  logic [3:0]  cmd0;
  logic dout1, oe1, rdy1, en1, hz1, stb1;
  logic [17:0] in1;
  logic [3:0]  cmd1;

  int total = 0, bad = 0, n_stb0 = 0, n_stb1 = 0, slot = 0;
  logic s_dout [1:64];
  logic s_oe   [1:64];

  always #2.5 clk = ~clk;

  spi_cmd_slave u0 (.clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .din(din),
    .dout(dout0), .dout_oe(oe0), .ready_n(rdy0), .input_reg(in0), .echo_en(en0),
    .hiz_after(hz0), .exec_stb(stb0), .exec_cmd(cmd0));

  spi_cmd_slave u1 (.clk(clk), .rst_n(rst_n), .cs_n(rdy0), .sclk(sclk), .din(din),
    .dout(dout1), .dout_oe(oe1), .ready_n(rdy1), .input_reg(in1), .echo_en(en1),
    .hiz_after(hz1), .exec_stb(stb1), .exec_cmd(cmd1));

  always @(posedge clk) begin
    if (rst_n && stb0) n_stb0 <= n_stb0 + 1;
    if (rst_n && stb1) n_stb1 <= n_stb1 + 1;
  end

  // {bits, frame (MSB first from bit 31), expected input_reg, expected cfg}
  localparam logic [59:0] VEC [10] = '{
    {8'd24, 4'h4, 18'h00001, 2'b00, 8'h00, 18'h00000, 2'b01},
    {8'd24, 4'h1, 18'h2AB3C, 2'b11, 8'h00, 18'h2AB3C, 2'b01},
    {8'd20, 4'h1, 18'h15555, 2'b00, 8'h00, 18'h2AB3C, 2'b01},
    {8'd30, 4'h1, 18'h0F0F1, 2'b01, 8'hFC, 18'h0F0F1, 2'b01},
    {8'd24, 4'h9, 18'h00000, 2'b10, 8'h00, 18'h0F0F1, 2'b01},
    {8'd24, 4'h0, 18'h3FFFF, 2'b11, 8'h00, 18'h0F0F1, 2'b01},
    {8'd24, 4'h4, 18'h00003, 2'b00, 8'h00, 18'h0F0F1, 2'b11},
    {8'd24, 4'hC, 18'h00000, 2'b01, 8'h00, 18'h0F0F1, 2'b11},
    {8'd24, 4'h1, 18'h3FFFF, 2'b10, 8'h00, 18'h3FFFF, 2'b11},
    {8'd12, 4'h4, 18'h00000, 2'b00, 8'h00, 18'h3FFFF, 2'b11}
  };

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cs_low();
    slot = 0;
    cs_n = 0;
    tick(H);
  endtask

  task automatic bit_out(input logic b);
    sclk = 1;
    din  = b;
    tick(H - 1);
    slot++;
    s_dout[slot] = dout0;
    s_oe[slot]   = oe0;
    tick(1);
    sclk = 0;
    tick(H);
  endtask

  task automatic cs_high();
    tick(H);
    cs_n = 1;
    tick(2 * H);
  endtask

  task automatic send(input logic [63:0] w, input int n);
    cs_low();
    for (int i = 0; i < n; i++) bit_out(w[63-i]);
    cs_high();
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic [17:0] m_in;
    logic [1:0]  m_cfg;
    logic        m_drv;
    int          m_stb;

    tick(4);
    // R12 reset state
    chk("R12 input_reg", 32'(in0), 0);
    chk("R12 cfg", 32'({hz0, en0}), 0);
    chk("R12 ready_n", 32'(rdy0), 1);
    chk("R12 exec_stb", 32'(stb0), 0);
    chk("R7 oe at reset", 32'(oe0), 0);
    rst_n = 1;
    tick(4);
    chk("R12 exec_cmd", 32'(cmd0), 0);

    m_in = '0; m_cfg = '0; m_drv = 0; m_stb = 0;
    for (int e = 0; e < 10; e++) begin
      int n, last, bad_slots;
      logic [31:0] fr;
      logic [17:0] rbw;
      logic rb, full, exp_b;
      n    = int'(VEC[e][59:52]);
      fr   = VEC[e][51:20];
      full = (n >= 24);
      rb   = fr[31];
      rbw  = (fr[30:28] == 3'd1) ? m_in : (fr[30:28] == 3'd4) ? {16'b0, m_cfg} : 18'h0;
      send({fr, 32'h0}, n);
      last = (n < 24) ? n : 24;
      bad_slots = 0;
      exp_b = 0;
      for (int k = 1; k <= last; k++) begin
        if (k == 1) exp_b = 1'b0;
        else if (rb && full && k >= 6 && k <= 23) exp_b = rbw[23-k];
        else exp_b = fr[33-k];
        if (m_cfg[0] && (s_oe[k] !== 1'b1 || s_dout[k] !== exp_b)) bad_slots++;
        if (!m_cfg[0] && s_oe[k] !== 1'b0) bad_slots++;
      end
      // R6 R7 R10 echo slots, count of mismatching slots
      chk($sformatf("R6/R10 echo entry %0d", e), 32'(bad_slots), 0);
      if (m_cfg[0]) m_drv = 1;
      if (full) m_stb++;
      m_in  = VEC[e][19:2];
      m_cfg = VEC[e][1:0];
      if (full && (!m_cfg[0] || m_cfg[1])) m_drv = 0;
      if (m_cfg[1]) m_drv = 0;
      // R1 R3 R4 register contents
      chk($sformatf("R1/R3/R4 input_reg entry %0d", e), 32'(in0), 32'(m_in));
      // R2 R3 configuration
      chk($sformatf("R2/R3 cfg entry %0d", e), 32'({hz0, en0}), 32'(m_cfg));
      chk($sformatf("R1/R3 strobe count entry %0d", e), 32'(n_stb0), 32'(m_stb));
      if (full) chk($sformatf("R1 exec_cmd entry %0d", e), 32'(cmd0), 32'(fr[31:28]));
      // R8 after-frame line state
      chk($sformatf("R8 oe after entry %0d", e), 32'(oe0), 32'(m_drv));
      if (m_drv) chk($sformatf("R8 held bit entry %0d", e), 32'(dout0), 32'(exp_b));
    end

    // R5 clocks with select high
    din = 1;
    for (int i = 0; i < 30; i++) begin
      sclk = 1; tick(H);
      sclk = 0; tick(H);
    end
    chk("R5 strobe count", 32'(n_stb0), 32'(m_stb));
    chk("R5 ready_n", 32'(rdy0), 1);
    send({4'h1, 18'h00ABC, 2'b00, 40'h0}, 24);
    chk("R5 next frame decoded", 32'(in0), 32'h00ABC);

    // R9 ready timing
    cs_low();
    for (int i = 0; i < 23; i++) bit_out(1'b0);
    chk("R9 ready_n after 23 bits", 32'(rdy0), 1);
    bit_out(1'b0);
    chk("R9 ready_n after 24 bits", 32'(rdy0), 0);
    cs_high();
    chk("R9 ready_n after select high", 32'(rdy0), 1);

    // R11 two-device chain: no-op to first, write to second
    m_stb = n_stb0;
    send({4'h0, 18'h3FFFF, 2'b00, 4'h1, 18'h12345, 2'b00, 16'h0}, 48);
    chk("R11 first device unchanged", 32'(in0), 32'h00ABC);
    chk("R11 first device strobes once", 32'(n_stb0), 32'(m_stb + 1));
    chk("R11 second device written", 32'(in1), 32'h12345);
    chk("R11 second device command", 32'(cmd1), 32'h1);
    chk("R7 second device echo off", 32'(oe1), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule